// File: doc/BRIEF.md
# Multiply-Accumulate Execution Unit with HI/LO Accumulator

This unit is an integer execution slice for a 64-bit core. It multiplies the low 32 bits of two source operands, either signed or unsigned, into a full 64-bit product. It then combines that product with a 64-bit accumulator that is held across two architectural registers, HI and LO. Each operation starts either from zero or from the current accumulator value, and either adds or subtracts the product. Most forms also return half of the new accumulator to a general register.

A decoder reads the instruction word and turns it into a small control record. The record holds the signedness, the zero-or-accumulator base, the add-or-subtract choice, which half goes back to a register, and whether a register write happens at all. The writeback strobe, index and value are combinational in the cycle the instruction is valid. HI and LO change on the following clock edge. A word the unit does not recognise raises a flag and touches nothing.

Top module: `mac_hilo_unit`

## Requirements
- R1: While reset is asserted, and right after it is released, HI and LO both read as zero.
- R2: The accumulator is formed from HI[31:0] (upper half) and LO[31:0] (lower half). After an update, HI holds the new accumulator bits 63:32 and LO holds bits 31:0, each sign-extended from its bit 31 to 64 bits.
- R3: The product is the exact 64-bit product of src_a[31:0] and src_b[31:0]. It is unsigned when function 101000 is used with sub-op bit 0 set, or when function 011001 is used. It is signed in every other case. Upper source bits have no effect.
- R4: Opcode bits 31:26 = 000000 with function bits 5:0 = 101000 selects the replace forms. Sub-op bits 10:6 of 00100, 00101, 01100 or 01101 load the accumulator with the product.
- R5: With function 101000, sub-op 00010, 00011, 01010 or 01011 adds the product to the accumulator.
- R6: Functions 011000 (signed) and 011001 (unsigned) select the negating forms. Sub-op 00011 or 01011 loads zero minus the product. Sub-op 00111 or 01111 loads the accumulator minus the product.
- R7: Every form in R4 to R6 asserts wb_en in the same cycle as instr_valid. wb_idx is taken from bits 15:11. wb_data is the new accumulator bits 31:0 when sub-op bit 3 is 0, or bits 63:32 when it is 1, sign-extended to 64 bits.
- R8: Function 101000 with bits 15:6 all zero adds the signed product to the accumulator and does not assert wb_en.
- R9: Function 101001 with bits 15:6 all zero adds the signed product to the full 64-bit LO. HI stays unchanged and wb_en stays low.
- R10: A valid word that matches none of the encodings in R4 to R9 sets unsupported in the same cycle. wb_en stays low, and HI and LO do not change.
- R11: While instr_valid is low, wb_en and unsupported are low and HI and LO hold their values.
- R12: Accumulator arithmetic wraps modulo 2^64, with no overflow indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr_word | input | 32 | Instruction word |
| src_a | input | 64 | First source register value |
| src_b | input | 64 | Second source register value |
| wb_en | output | 1 | Destination register write strobe |
| wb_idx | output | 5 | Destination register index |
| wb_data | output | 64 | Destination register value |
| unsupported | output | 1 | Valid word not recognised by this unit |
| hi_q | output | 64 | HI register contents |
| lo_q | output | 64 | LO register contents |

## Verification
The assertions run on every cycle. They check that HI always carries a sign-extended upper half, that any written value is sign-extended from bit 31, and that HI and LO stay frozen on idle cycles and on unrecognised words. They also check that the LO-only form never moves HI and that a write strobe never appears without a valid, recognised word. The actual arithmetic can only be shown by the bench scenarios. These cover the signed and unsigned product of operands that carry junk in their upper halves, accumulation and subtraction chains that wrap past 2^64, and selection of the high or low half. They also show that an accumulate following the LO-only form reads just LO's low 32 bits.

// File: rtl/macu_pkg.sv
package macu_pkg;

   // Instruction field positions; the decode depends on them.
   localparam int unsigned OPC_LSB = 26;
   localparam int unsigned DST_LSB = 11;
   localparam int unsigned SUB_LSB = 6;
   localparam int unsigned FUN_LSB = 0;

   localparam logic [5:0] FN_MADD   = 6'b101000;
   localparam logic [5:0] FN_NEG_S  = 6'b011000;
   localparam logic [5:0] FN_NEG_U  = 6'b011001;
   localparam logic [5:0] FN_LOADD  = 6'b101001;

   typedef struct packed {
      logic legal;      // word recognised
      logic is_uns;     // operands unsigned
      logic use_acc;    // base is accumulator, else zero
      logic negate;     // subtract product
      logic take_high;  // writeback upper half
      logic write_rd;   // general register written
      logic lo_only;    // full-width add into LO only
   } macu_ctl_t;

endpackage

// File: rtl/macu_decode.sv
module macu_decode
   import macu_pkg::*;
(
   input  logic [5:0] opc,
   input  logic [4:0] dst,
   input  logic [4:0] sub,
   input  logic [5:0] fun,
   output macu_ctl_t  ctl
);

   always_comb begin
      ctl = '0;
      if (opc == 6'b000000) begin
         unique case (fun)
            FN_MADD: begin
               unique case (sub)
                  5'b00000: begin
                     if (dst == 5'd0) begin
                        ctl.legal   = 1'b1;
                        ctl.use_acc = 1'b1;
                     end
                  end
                  5'b00100, 5'b00101, 5'b01100, 5'b01101: begin
                     ctl.legal     = 1'b1;
                     ctl.write_rd  = 1'b1;
                     ctl.is_uns    = sub[0];
                     ctl.take_high = sub[3];
                  end
                  5'b00010, 5'b00011, 5'b01010, 5'b01011: begin
                     ctl.legal     = 1'b1;
                     ctl.write_rd  = 1'b1;
                     ctl.use_acc   = 1'b1;
                     ctl.is_uns    = sub[0];
                     ctl.take_high = sub[3];
                  end
                  default: ctl = '0;
               endcase
            end
            FN_NEG_S, FN_NEG_U: begin
               unique case (sub)
                  5'b00011, 5'b01011, 5'b00111, 5'b01111: begin
                     ctl.legal     = 1'b1;
                     ctl.write_rd  = 1'b1;
                     ctl.negate    = 1'b1;
                     ctl.is_uns    = fun[0];
                     ctl.use_acc   = sub[2];
                     ctl.take_high = sub[3];
                  end
                  default: ctl = '0;
               endcase
            end
            FN_LOADD: begin
               if (dst == 5'd0 && sub == 5'd0) begin
                  ctl.legal   = 1'b1;
                  ctl.use_acc = 1'b1;
                  ctl.lo_only = 1'b1;
               end
            end
            default: ctl = '0;
         endcase
      end
   end

endmodule

// File: rtl/macu_mult.sv
module macu_mult #(
   parameter int unsigned OPW     = 32,
   parameter int unsigned VARIANT = 0
) (
   input  logic [OPW-1:0]   opa,
   input  logic [OPW-1:0]   opb,
   input  logic             is_uns,
   output logic [2*OPW-1:0] prod
);

   localparam int unsigned PW = 2 * OPW;

   if (VARIANT > 1) begin : g_bad_variant
      $error("macu_mult: VARIANT must be 0 or 1");
   end

   if (VARIANT == 0) begin : g_ext
      // one signed multiplier on operands widened by one bit
      logic signed [OPW:0]    ea;
      logic signed [OPW:0]    eb;
      logic signed [PW+1:0]   full;
      assign ea   = {~is_uns & opa[OPW-1], opa};
      assign eb   = {~is_uns & opb[OPW-1], opb};
      assign full = ea * eb;
      assign prod = full[PW-1:0];
   end else begin : g_dual
      // separate signed and unsigned multipliers, muxed
      logic signed [PW-1:0] sp;
      logic        [PW-1:0] up;
      assign sp   = $signed(opa) * $signed(opb);
      assign up   = {{OPW{1'b0}}, opa} * {{OPW{1'b0}}, opb};
      assign prod = is_uns ? up : sp;
   end

endmodule

// File: rtl/macu_acc.sv
module macu_acc #(
   parameter int unsigned XLEN = 64,
   parameter int unsigned OPW  = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            upd_en,
   input  logic            use_acc,
   input  logic            negate,
   input  logic            lo_only,
   input  logic [XLEN-1:0] prod,
   output logic [XLEN-1:0] acc_new,
   output logic [XLEN-1:0] hi_q,
   output logic [XLEN-1:0] lo_q
);

   localparam int unsigned EXT = XLEN - OPW;

   logic [XLEN-1:0] acc_cur;
   logic [XLEN-1:0] base;
   logic [XLEN-1:0] term;
   logic [XLEN-1:0] lo_sum;

   assign acc_cur = {hi_q[OPW-1:0], lo_q[OPW-1:0]};
   assign base    = use_acc ? acc_cur : '0;
   assign term    = negate ? (~prod + XLEN'(1)) : prod;
   assign acc_new = base + term;
   assign lo_sum  = lo_q + prod;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q <= '0;
         lo_q <= '0;
      end else if (upd_en) begin
         if (lo_only) begin
            lo_q <= lo_sum;
         end else begin
            hi_q <= {{EXT{acc_new[XLEN-1]}}, acc_new[XLEN-1:OPW]};
            lo_q <= {{EXT{acc_new[OPW-1]}}, acc_new[OPW-1:0]};
         end
      end
   end

endmodule

// File: rtl/mac_hilo_unit.sv
module mac_hilo_unit
   import macu_pkg::*;
#(
   parameter int unsigned XLEN         = 64,
   parameter int unsigned OPW          = 32,
   parameter int unsigned IW           = 32,
   parameter int unsigned RIDX         = 5,
   parameter int unsigned MULT_VARIANT = 0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            instr_valid,
   input  logic [IW-1:0]   instr_word,
   input  logic [XLEN-1:0] src_a,
   input  logic [XLEN-1:0] src_b,
   output logic            wb_en,
   output logic [RIDX-1:0] wb_idx,
   output logic [XLEN-1:0] wb_data,
   output logic            unsupported,
   output logic [XLEN-1:0] hi_q,
   output logic [XLEN-1:0] lo_q
);

   localparam int unsigned EXT = XLEN - OPW;

   if (XLEN != 2 * OPW) begin : g_bad_width
      $error("mac_hilo_unit: XLEN must be twice OPW");
   end
   if (IW != 32 || RIDX != 5) begin : g_bad_fmt
      $error("mac_hilo_unit: instruction format needs IW=32, RIDX=5");
   end

   macu_ctl_t       ctl;
   logic [XLEN-1:0] prod;
   logic [XLEN-1:0] acc_new;
   logic            unused_bits;

   assign unused_bits = ^{instr_word[25:16], src_a[XLEN-1:OPW], src_b[XLEN-1:OPW]};

   macu_decode u_dec (
      .opc (instr_word[OPC_LSB +: 6]),
      .dst (instr_word[DST_LSB +: 5]),
      .sub (instr_word[SUB_LSB +: 5]),
      .fun (instr_word[FUN_LSB +: 6]),
      .ctl (ctl)
   );

   macu_mult #(.OPW(OPW), .VARIANT(MULT_VARIANT)) u_mul (
      .opa    (src_a[OPW-1:0]),
      .opb    (src_b[OPW-1:0]),
      .is_uns (ctl.is_uns),
      .prod   (prod)
   );

   macu_acc #(.XLEN(XLEN), .OPW(OPW)) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .upd_en  (instr_valid & ctl.legal),
      .use_acc (ctl.use_acc),
      .negate  (ctl.negate),
      .lo_only (ctl.lo_only),
      .prod    (prod),
      .acc_new (acc_new),
      .hi_q    (hi_q),
      .lo_q    (lo_q)
   );

   assign wb_en       = instr_valid & ctl.legal & ctl.write_rd;
   assign wb_idx      = instr_word[DST_LSB +: RIDX];
   assign wb_data     = ctl.take_high ? {{EXT{acc_new[XLEN-1]}}, acc_new[XLEN-1:OPW]}
                                      : {{EXT{acc_new[OPW-1]}}, acc_new[OPW-1:0]};
   assign unsupported = instr_valid & ~ctl.legal;

endmodule

// File: rtl/macu_checker.sv
module macu_checker #(
   parameter int unsigned XLEN = 64,
   parameter int unsigned OPW  = 32,
   parameter int unsigned IW   = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            instr_valid,
   input logic [IW-1:0]   instr_word,
   input logic            wb_en,
   input logic [XLEN-1:0] wb_data,
   input logic            unsupported,
   input logic [XLEN-1:0] hi_q,
   input logic [XLEN-1:0] lo_q
);

   logic is_loadd;
   logic unused_chk;
   assign is_loadd   = instr_valid && instr_word[31:26] == 6'b000000
                       && instr_word[5:0] == 6'b101001;
   assign unused_chk = ^instr_word[25:6];

   p_hi_sext_r2: assert property (@(posedge clk) disable iff (!rst_n)
      hi_q[XLEN-1:OPW] == {(XLEN-OPW){hi_q[OPW-1]}});

   p_wb_sext_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> wb_data[XLEN-1:OPW] == {(XLEN-OPW){wb_data[OPW-1]}});

   p_wb_needs_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> instr_valid);

   p_loadd_keeps_hi_r9: assert property (@(posedge clk) disable iff (!rst_n)
      is_loadd |=> $stable(hi_q));

   p_unsup_no_wb_r10: assert property (@(posedge clk) disable iff (!rst_n)
      unsupported |-> !wb_en);

   p_unsup_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      unsupported |=> $stable(hi_q) && $stable(lo_q));

   p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !instr_valid |-> !wb_en && !unsupported);

   p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !instr_valid |=> $stable(hi_q) && $stable(lo_q));

endmodule

bind mac_hilo_unit macu_checker #(.XLEN(XLEN), .OPW(OPW), .IW(IW)) u_macu_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .instr_valid (instr_valid),
   .instr_word  (instr_word),
   .wb_en       (wb_en),
   .wb_data     (wb_data),
   .unsupported (unsupported),
   .hi_q        (hi_q),
   .lo_q        (lo_q)
);

// File: tb/test_mac_hilo_unit.sv
module test_mac_hilo_unit;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        instr_valid = 1'b0;
   logic [31:0] instr_word = '0;
   logic [63:0] src_a = '0;
   logic [63:0] src_b = '0;
   logic        wb_en;
   logic [4:0]  wb_idx;
   logic [63:0] wb_data;
   logic        unsupported;
   logic [63:0] hi_q;
   logic [63:0] lo_q;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   typedef struct {
      logic        wb_en;
      logic [4:0]  idx;
      logic [63:0] data;
      logic        unsup;
      logic [63:0] hi;
      logic [63:0] lo;
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   logic [63:0] m_hi = '0;
   logic [63:0] m_lo = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mac_hilo_unit i_mac_hilo_unit (
      .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
      .src_a(src_a), .src_b(src_b), .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
      .unsupported(unsupported), .hi_q(hi_q), .lo_q(lo_q)
   );

   task automatic chk(string tag, logic [63:0] act, logic [63:0] expv);
      checks++;
      if (act !== expv) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   function automatic logic [31:0] mk(logic [5:0] fn, logic [4:0] sub, logic [4:0] rd);
      return {6'b000000, 5'd9, 5'd10, rd, sub, fn};
   endfunction

   function automatic logic [63:0] sx(logic [31:0] v);
      return {{32{v[31]}}, v};
   endfunction

   // Reference model built from the requirement text
   task automatic issue(bit valid, logic [31:0] w, logic [63:0] a, logic [63:0] b, string tag);
      exp_t e;
      bit legal = 0, unsg = 0, acc = 0, neg = 0, high = 0, wr = 0, lonly = 0;
      logic [63:0] p, cur, nw;
      @(negedge clk);
      instr_valid = valid; instr_word = w; src_a = a; src_b = b;
      if (w[31:26] == 6'd0) begin
         if (w[5:0] == 6'b101000) begin
            if (w[10:6] == 5'b00000 && w[15:11] == 5'd0) begin legal = 1; acc = 1; end
            if (w[10:6] inside {5'b00100, 5'b00101, 5'b01100, 5'b01101}) begin
               legal = 1; wr = 1; unsg = w[6]; high = w[9];
            end
            if (w[10:6] inside {5'b00010, 5'b00011, 5'b01010, 5'b01011}) begin
               legal = 1; wr = 1; acc = 1; unsg = w[6]; high = w[9];
            end
         end else if (w[5:0] == 6'b011000 || w[5:0] == 6'b011001) begin
            if (w[10:6] inside {5'b00011, 5'b01011, 5'b00111, 5'b01111}) begin
               legal = 1; wr = 1; neg = 1; unsg = (w[5:0] == 6'b011001);
               acc = w[8]; high = w[9];
            end
         end else if (w[5:0] == 6'b101001 && w[15:6] == 10'd0) begin
            legal = 1; acc = 1; lonly = 1;
         end
      end
      if (unsg) p = {32'd0, a[31:0]} * {32'd0, b[31:0]};
      else      p = sx(a[31:0]) * sx(b[31:0]);
      cur = acc ? {m_hi[31:0], m_lo[31:0]} : 64'd0;
      nw  = neg ? cur - p : cur + p;
      e.tag   = tag;
      e.unsup = valid && !legal;
      e.wb_en = valid && legal && wr;
      e.idx   = w[15:11];
      e.data  = high ? sx(nw[63:32]) : sx(nw[31:0]);
      if (valid && legal) begin
         if (lonly) m_lo = m_lo + p;
         else begin m_hi = sx(nw[63:32]); m_lo = sx(nw[31:0]); end
      end
      e.hi = m_hi;
      e.lo = m_lo;
      exp_q.push_back(e);
   endtask

   // Monitor: pops expectations and compares against the outputs
   initial begin : monitor
      forever begin
         @(negedge clk);
         #(CLK_PERIOD/4);
         if (exp_q.size() != 0) begin
            exp_t e;
            e = exp_q.pop_front();
            chk({e.tag, " R7 wb_en"}, {63'd0, wb_en}, {63'd0, e.wb_en});
            if (e.wb_en) begin
               chk({e.tag, " R7 wb_idx"}, {59'd0, wb_idx}, {59'd0, e.idx});
               chk({e.tag, " wb_data"}, wb_data, e.data);
            end
            chk({e.tag, " R10 unsupported"}, {63'd0, unsupported}, {63'd0, e.unsup});
            @(posedge clk);
            #1;
            chk({e.tag, " R2 hi"}, hi_q, e.hi);
            chk({e.tag, " R2 lo"}, lo_q, e.lo);
         end
      end
   end

   initial begin : watchdog
      #(CLK_PERIOD * 20000);
      if (!finished) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : driver
      repeat (3) @(posedge clk);
      #1;
      chk("R1 hi in reset", hi_q, 64'd0);
      chk("R1 lo in reset", lo_q, 64'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      chk("R1 hi after release", hi_q, 64'd0);
      chk("R1 lo after release", lo_q, 64'd0);

      // R4/R3 signed replace; upper source bits are junk
      issue(1, mk(6'b101000, 5'b00100, 5'd3),  64'hDEAD_BEEF_FFFF_FFFE, 64'h1234_5678_0000_0003, "R4 R3 mul signed");
      issue(1, mk(6'b101000, 5'b01100, 5'd31), 64'h0000_0001_8000_0000, 64'hFFFF_0000_8000_0000, "R4 R7 mul high signed");
      issue(1, mk(6'b101000, 5'b00101, 5'd4),  64'hAAAA_AAAA_FFFF_FFFF, 64'h5555_5555_FFFF_FFFF, "R3 mul unsigned low");
      issue(1, mk(6'b101000, 5'b01101, 5'd5),  64'h0000_0000_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF, "R3 R7 mul unsigned high");
      // R5 accumulate forms
      issue(1, mk(6'b101000, 5'b00010, 5'd6),  64'd5, 64'd7, "R5 acc signed low");
      issue(1, mk(6'b101000, 5'b00011, 5'd7),  64'h0000_0000_FFFF_FFFF, 64'd2, "R5 acc unsigned low");
      issue(1, mk(6'b101000, 5'b01010, 5'd8),  64'h0000_0000_FFFF_FFFF, 64'd1, "R5 acc signed high");
      issue(1, mk(6'b101000, 5'b01011, 5'd17), 64'h10, 64'h1000_0000, "R12 R5 acc unsigned high wrap");
      // R8 plain accumulate, no write
      issue(1, mk(6'b101000, 5'b00000, 5'd0),  64'd3, 64'hFFFF_FFFF_FFFF_FFFC, "R8 mac no write");
      // R11 idle
      issue(0, mk(6'b101000, 5'b00100, 5'd2),  64'd9, 64'd9, "R11 idle");
      // R6 negating forms
      issue(1, mk(6'b011000, 5'b00111, 5'd9),  64'd100, 64'd1, "R6 R12 acc minus signed");
      issue(1, mk(6'b011000, 5'b00011, 5'd10), 64'hFFFF_FFFE, 64'd3, "R6 zero minus signed");
      issue(1, mk(6'b011001, 5'b01111, 5'd11), 64'hFFFF_FFFF, 64'hFFFF_FFFF, "R6 acc minus unsigned high");
      issue(1, mk(6'b011001, 5'b01011, 5'd12), 64'h8000_0000, 64'h3, "R6 zero minus unsigned high");
      issue(1, mk(6'b011000, 5'b01011, 5'd13), 64'h7FFF_FFFF, 64'h7FFF_FFFF, "R6 zero minus signed high");
      issue(1, mk(6'b011001, 5'b00111, 5'd14), 64'd2, 64'd3, "R6 acc minus unsigned low");
      // R9 LO-only add, then accumulate reading LO low half
      issue(1, mk(6'b101001, 5'b00000, 5'd0),  64'h7FFF_FFFF, 64'h7FFF_FFFF, "R9 lo only add");
      issue(1, mk(6'b101000, 5'b00010, 5'd15), 64'd1, 64'd1, "R2 acc after lo only");
      issue(1, mk(6'b101001, 5'b00000, 5'd0),  64'hFFFF_FFFF, 64'd5, "R9 lo only negative");
      // R10 unrecognised words
      issue(1, 32'h0400_0028, 64'd3, 64'd3, "R10 wrong opcode");
      issue(1, mk(6'b101000, 5'b00001, 5'd1),  64'd3, 64'd3, "R10 bad subop");
      issue(1, mk(6'b101000, 5'b00000, 5'd3),  64'd3, 64'd3, "R10 R8 mac with rd");
      issue(1, mk(6'b011000, 5'b00100, 5'd1),  64'd3, 64'd3, "R10 negate bad subop");
      issue(1, mk(6'b101001, 5'b00000, 5'd2),  64'd3, 64'd3, "R10 R9 lo add with rd");
      issue(1, mk(6'b000000, 5'b00100, 5'd2),  64'd3, 64'd3, "R10 wrong function");
      issue(0, 32'd0, 64'd0, 64'd0, "R11 final idle");
      repeat (4) @(negedge clk);
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule